// File: doc/BRIEF.md
# Inertial Symbol Clock Recovery Loop

This block recovers the symbol timing from a hard-sliced demodulator bit stream. A signed phase accumulator advances by a programmable step on each valid input sample. When the accumulator wraps from the positive half to the negative half, the block takes the current data bit as the symbol decision and pulses a symbol strobe.

Each change of the sliced data between valid samples counts as a transition. At a transition the accumulator is scaled toward zero by an inertia factor. An external lock input selects which factor applies: a high-inertia factor while the carrier is locked, and a lower one while the loop is still acquiring.

On every transition the block also reports the accumulator value before the correction, together with a strobe. A separate lock detector can score from these reports how close the edges fall to the ideal point.

Top module: `dpll_clk_recover`

## Requirements
- R1: While reset is low, and after it is released, the phase, the remembered data bit, `bit_out`, `edge_phase` and both strobes are zero.
- R2: On each clock with `smp_vld` high, the phase advances by `step` modulo 2^PH_W. `step` is read as an unsigned number.
- R3: A wrap is a valid sample where the phase before the increment has MSB 0 and the incremented phase has MSB 1. On the next clock `bit_vld` is high for one cycle, and `bit_out` holds the `data_in` value of that sample until the next wrap.
- R4: A transition is a valid sample where `data_in` differs from `data_in` at the previous valid sample, or from 0 if there has been no valid sample since reset. On the next clock `edge_vld` is high for one cycle.
- R5: Together with `edge_vld`, `edge_phase` gives the incremented phase of that sample before correction, as a two's-complement value. It holds its value between transitions.
- R6: At a transition with `lock_in` high, the new phase is the incremented phase times `inertia_lock` / 2^INR_W, truncated toward zero.
- R7: At a transition with `lock_in` low, the new phase uses the same rule with `inertia_acq`.
- R8: A clock with `smp_vld` low leaves the phase and the remembered data bit unchanged, and both strobes are low on the next clock. A change of `data_in` during such a clock is ignored.
- R9: When a wrap and a transition occur on the same sample, both strobes fire. The wrap decision uses the phase before correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Input sample valid |
| data_in | input | 1 | Hard-sliced data bit |
| step | input | PH_W | Phase increment per sample (unsigned) |
| inertia_lock | input | INR_W | Scale factor used while locked, unsigned fraction over 2^INR_W |
| inertia_acq | input | INR_W | Scale factor used while acquiring |
| lock_in | input | 1 | External lock indication |
| bit_out | output | 1 | Recovered symbol bit |
| bit_vld | output | 1 | Symbol strobe, one cycle |
| edge_vld | output | 1 | Transition strobe, one cycle |
| edge_phase | output | PH_W | Phase at the last transition, before correction |

## Verification
The bench builds the block with PH_W = 10 and INR_W = 4. With these values every inertia factor can be swept exhaustively: all 16 values, in both lock states, with the other factor set to a different value. The phase space is small enough that a wrap occurs every few samples at the chosen steps, so wraps, transitions, coincident events, idle gaps and negative-product rounding all occur many times. The expected phase is computed arithmetically with integer division and compared each sample through `edge_phase` and the wrap timing.

// File: rtl/dpll_clk_recover.sv
module dpll_clk_recover #(
  parameter int PH_W  = 32,
  parameter int INR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic             data_in,
  input  logic [PH_W-1:0]  step,
  input  logic [INR_W-1:0] inertia_lock,
  input  logic [INR_W-1:0] inertia_acq,
  input  logic             lock_in,
  output logic             bit_out,
  output logic             bit_vld,
  output logic             edge_vld,
  output logic [PH_W-1:0]  edge_phase
);
  localparam int PW = PH_W + INR_W + 1;

  logic [PH_W-1:0] phase, ph_inc, corr_ph;
  logic            prev_d, wrap, edge_hit;
  logic [INR_W-1:0] fac;
  logic signed [PW-1:0] prod, biased;
  logic [PW-1:0] rnd;

  assign ph_inc   = PH_W'(phase + step);
  assign wrap     = !phase[PH_W-1] && ph_inc[PH_W-1];
  assign edge_hit = data_in != prev_d;
  assign fac      = lock_in ? inertia_lock : inertia_acq;

  assign prod    = $signed({{(INR_W+1){ph_inc[PH_W-1]}}, ph_inc})
                 * $signed({{(PH_W+1){1'b0}}, fac});
  assign rnd     = {{(PW-INR_W){1'b0}}, {INR_W{prod[PW-1]}}};
  assign biased  = prod + $signed(rnd);
  assign corr_ph = biased[INR_W +: PH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= '0;
      prev_d     <= 1'b0;
      bit_out    <= 1'b0;
      bit_vld    <= 1'b0;
      edge_vld   <= 1'b0;
      edge_phase <= '0;
    end else begin
      bit_vld  <= 1'b0;
      edge_vld <= 1'b0;
      if (smp_vld) begin
        prev_d <= data_in;
        phase  <= edge_hit ? corr_ph : ph_inc;
        if (wrap) begin
          bit_out <= data_in;
          bit_vld <= 1'b1;
        end
        if (edge_hit) begin
          edge_vld   <= 1'b1;
          edge_phase <= ph_inc;
        end
      end
    end
  end

  logic [PH_W:0] mag_ph, mag_edge;
  assign mag_ph   = phase[PH_W-1] ? (PH_W+1)'(-$signed({1'b1, phase})) : {1'b0, phase};
  assign mag_edge = edge_phase[PH_W-1] ? (PH_W+1)'(-$signed({1'b1, edge_phase})) : {1'b0, edge_phase};

  a_r3_strobe_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(smp_vld));
  a_r4_edge_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld |-> $past(smp_vld));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!bit_vld && !edge_vld && $stable(phase)));
  a_r6_pull_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld |-> (mag_ph <= mag_edge));
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (phase == '0 && !bit_vld && !edge_vld));
endmodule

// File: tb/dpll_clk_recover_tb.sv
module dpll_clk_recover_tb;
  localparam int PH_W = 10;
  localparam int INR_W = 4;
  localparam int MODV = 1 << PH_W;
  localparam int HALF = 1 << (PH_W-1);

  logic clk = 0, rst_n = 0, smp_vld = 0, data_in = 0, lock_in = 0;
  logic [PH_W-1:0] step = '0;
  logic [INR_W-1:0] inertia_lock = '0, inertia_acq = '0;
  logic bit_out, bit_vld, edge_vld;
  logic [PH_W-1:0] edge_phase;

  int checks = 0, errors = 0;
  int m_ph = 0, m_pd = 0, m_bit = 0, m_ep = 0, m_bv = 0, m_ev = 0;
  string ptag = "R5";
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  dpll_clk_recover #(.PH_W(PH_W), .INR_W(INR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .data_in(data_in),
    .step(step), .inertia_lock(inertia_lock), .inertia_acq(inertia_acq),
    .lock_in(lock_in), .bit_out(bit_out), .bit_vld(bit_vld),
    .edge_vld(edge_vld), .edge_phase(edge_phase));

  function automatic int wrapv(int v);
    int r = ((v % MODV) + MODV) % MODV;
    return (r >= HALF) ? r - MODV : r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk((m_bv && m_ev) ? "R9" : "R3", int'(bit_vld), m_bv);
    chk("R3", int'(bit_out), m_bit);
    chk("R4", int'(edge_vld), m_ev);
    chk(ptag, int'($signed(edge_phase)), m_ep);
  endtask

  // Drives one sample at a negedge and advances the model; R2, R6, R7, R8
  task automatic drive(bit v, bit d, bit lk);
    int nx, f;
    smp_vld = v; data_in = d; lock_in = lk;
    m_bv = 0; m_ev = 0;
    if (v) begin
      nx = wrapv(m_ph + int'(step));
      if (m_ph >= 0 && nx < 0) begin m_bv = 1; m_bit = d; end
      if (int'(d) != m_pd) begin
        m_ev = 1; m_ep = nx;
        f = lk ? int'(inertia_lock) : int'(inertia_acq);
        m_ph = (nx * f) / (1 << INR_W);
        ptag = lk ? "R6" : "R7";
      end else m_ph = nx;
      m_pd = d;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; smp_vld = 0;
    repeat (2) @(negedge clk);
    m_ph = 0; m_pd = 0; m_bit = 0; m_ep = 0; m_bv = 0; m_ev = 0; ptag = "R5";
    chk("R1", int'(bit_vld), 0); chk("R1", int'(edge_vld), 0);
    chk("R1", int'(bit_out), 0); chk("R1", int'(edge_phase), 0);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8: data toggling while idle is ignored
    for (int i = 0; i < 6; i++) drive(0, i[0], 0);
    // R5: first edge after reset reports the unscaled phase; R2 step alone
    step = 10'd100; inertia_acq = 4'd8; inertia_lock = 4'd15;
    drive(1, 1, 0);
    chk("R5", int'($signed(edge_phase)), 100);
    for (int lk = 0; lk < 2; lk++) begin
      for (int f = 0; f < 16; f++) begin
        for (int s = 0; s < 4; s++) begin
          int stv [4] = '{37, 100, 255, 511};
          step = PH_W'(stv[s]);
          if (lk) begin inertia_lock = INR_W'(f); inertia_acq = INR_W'(15 - f); end
          else    begin inertia_acq = INR_W'(f); inertia_lock = INR_W'(15 - f); end
          for (int n = 0; n < 40; n++) begin
            bit v, d, k;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = (n % 7) != 6;
            d = (s[0]) ? lfsr[0] : (lfsr[3:0] == 4'h0 ? ~data_in : data_in);
            k = (n > 30) ? lfsr[5] : lk[0];
            drive(v, d, k);
          end
        end
      end
      if (lk == 0) do_reset();
    end
    do_reset();
    drive(1, 0, 0);
    chk("R2", int'(bit_vld), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule